// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits in a transmit path. For each frame it first takes a five-word command header, then the frame bytes. It stores the frame in an internal byte buffer. While the bytes arrive, it adds up a 16-bit ones'-complement sum from a start offset chosen by the header. When the frame ends, it decides whether to send the frame or drop it. If it sends the frame, it replays the frame on an output byte stream. If the header asks for it, the finished checksum replaces two bytes at a write offset that the header also chooses. The frame has to be held in full before release because the write offset may point at any byte, including bytes ahead of where the sum begins.

Two things can drop a frame: the transmit-enable input, and a length rule for tagged-size frames. A frame that is sent raises a one-cycle completion pulse and adds its length to a running 64-bit byte total. The block does no MAC framing, preamble or FCS work.

Top module: `tx_csum_insert`

## Requirements
- R1: A header is accepted only when `hdr_last` comes with its fifth word. If `hdr_last` comes with any other word, `hdr_err` pulses for one cycle, the header is discarded and `in_ready` stays low. While a header is awaited, `hdr_ready` is high and `in_ready` is low; the two are never high together.
- R2: When bit 0 of header word 0 is clear, every frame byte leaves unchanged.
- R3: The start offset is header word 1 bits 31:16. The checksum is computed as follows. Take the stored bytes from the start offset to the frame end and pair them as big-endian 16-bit words, padding an odd last byte with a zero low byte. Add these words and header word 2 bits 15:0 with end-around carry, then complement the result. A start offset at or past the frame end gives the complement of the seed.
- R4: The write offset is header word 1 bits 15:0. Checksum bit 15:8 replaces the byte at the write offset and bits 7:0 replace the next byte. The checksum is formed over the original bytes.
- R5: If the write offset is at or beyond the frame length minus 1, the frame leaves unmodified.
- R6: If `tx_en` is low when the last frame byte is accepted, the frame is consumed and produces no output, no `tx_done` and no change in `tx_bytes`.
- R7: If `jumbo_en` and `vlan_en` are both low, a frame of 1519 to 1522 bytes is dropped as in R6. If either input is high, or the length is outside that range, the frame is sent.
- R8: After the output handshake of the last byte, `tx_done` is high for exactly one cycle and `tx_bytes` grows by the frame length. `tx_bytes` changes at no other time.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. Every byte leaves exactly once, in order, and `out_last` is set on the final byte only.
- R10: Frame bytes beyond `BUF_BYTES` (default 2048) are accepted but dropped. The frame length, checksum and length rule then use the stored bytes only.
- R11: After reset `out_valid`, `tx_done` and `hdr_err` are low, `tx_bytes` is zero, `hdr_ready` is high and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable, sampled at frame end |
| jumbo_en | input | 1 | Allow long frames |
| vlan_en | input | 1 | Allow tagged-size frames |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Header word accepted |
| hdr_data | input | 32 | Header word |
| hdr_last | input | 1 | Final header word |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final frame byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte |
| tx_done | output | 1 | One-cycle frame-sent pulse |
| hdr_err | output | 1 | One-cycle bad-header pulse |
| tx_bytes | output | 64 | Total bytes sent |

## Verification
The assertions assume that the downstream side obeys the output handshake. A held byte is the only one it may take. `out_ready` is the only input the output checks depend on. The assertions also assume that the three policy inputs do not move in the cycle a frame ends. The stimulus meets these assumptions: it changes `tx_en`, `jumbo_en` and `vlan_en` only between frames. It drives every input one time unit after the rising edge, and it steps `out_ready` through fixed always-on, alternating and one-in-three-low patterns. Under those patterns the hold rule is observed both during stalls and during back-to-back transfers.

// File: rtl/ckin_pkg.sv
package ckin_pkg;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_FRM  = 2'd1,
    ST_SEND = 2'd2
  } ckin_st_e;

  typedef struct packed {
    logic        csum_en;
    logic [15:0] start_off;
    logic [15:0] wr_off;
    logic [15:0] seed;
  } ckin_cmd_t;

endpackage

// File: rtl/ckin_hdr_rx.sv
module ckin_hdr_rx
  import ckin_pkg::*;
#(
  parameter int WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        accept,
  input  logic        hdr_valid,
  input  logic [31:0] hdr_data,
  input  logic        hdr_last,
  output logic        hdr_ready,
  output ckin_cmd_t   cmd,
  output logic        done,
  output logic        err
);
  localparam int CW = $clog2(WORDS + 1);

  logic [CW-1:0] idx_q, idx_nx;
  ckin_cmd_t     cmd_q, cmd_nx;
  logic          hs;

  assign hdr_ready = accept;
  assign hs        = hdr_valid && accept;
  assign done      = hs && hdr_last && (idx_q == CW'(WORDS - 1));
  assign err       = hs && hdr_last && (idx_q != CW'(WORDS - 1));
  assign cmd       = cmd_q;

  always_comb begin
    idx_nx = idx_q;
    cmd_nx = cmd_q;
    if (hs) begin
      case (idx_q)
        CW'(0): cmd_nx.csum_en = hdr_data[0];
        CW'(1): begin
          cmd_nx.start_off = hdr_data[31:16];
          cmd_nx.wr_off    = hdr_data[15:0];
        end
        CW'(2): cmd_nx.seed = hdr_data[15:0];
        default: ;
      endcase
      if (hdr_last) begin
        idx_nx = '0;
      end else if (idx_q != CW'(WORDS)) begin
        idx_nx = idx_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cmd_q <= '0;
    end else if (hs) begin
      idx_q <= idx_nx;
      cmd_q <= cmd_nx;
    end
  end

endmodule

// File: rtl/ckin_sum.sv
module ckin_sum #(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] idx,
  input  logic [15:0]   start_off,
  input  logic [7:0]    data,
  input  logic [15:0]   seed,
  output logic [15:0]   csum
);
  logic [31:0] acc_q, acc_nx;
  logic [31:0] addend;
  logic        in_span;
  logic        low_half;
  logic [31:0] total;
  logic [16:0] fold1;
  logic [15:0] fold2;

  assign in_span  = 16'(idx) >= start_off;
  // byte parity relative to the start offset picks the half of the word
  assign low_half = idx[0] ^ start_off[0];
  assign addend   = low_half ? {24'd0, data} : {16'd0, data, 8'd0};

  always_comb begin
    acc_nx = acc_q;
    if (clr) begin
      acc_nx = '0;
    end else if (en && in_span) begin
      acc_nx = acc_q + addend;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr || en) begin
      acc_q <= acc_nx;
    end
  end

  assign total = acc_q + {16'd0, seed};
  assign fold1 = {1'b0, total[15:0]} + {1'b0, total[31:16]};
  assign fold2 = fold1[15:0] + {15'd0, fold1[16]};
  assign csum  = ~fold2;

endmodule

// File: rtl/ckin_fbuf.sv
module ckin_fbuf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import ckin_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int HDR_WORDS = 5,
  parameter int STD_MAX   = 1518,
  parameter int TAG_MAX   = 1522
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        jumbo_en,
  input  logic        vlan_en,
  input  logic        hdr_valid,
  output logic        hdr_ready,
  input  logic [31:0] hdr_data,
  input  logic        hdr_last,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        tx_done,
  output logic        hdr_err,
  output logic [63:0] tx_bytes
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = $clog2(BUF_BYTES + 1);

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  ckin_st_e    st_q, st_nx;
  logic [LW-1:0] cnt_q, cnt_nx;
  logic [LW-1:0] rd_q, rd_nx;
  logic        ov_q, ov_nx;
  logic [7:0]  od_q, od_nx;
  logic        ol_q, ol_nx;
  logic        done_q, done_nx;
  logic        err_q;
  logic [63:0] bytes_q, bytes_nx;

  ckin_cmd_t   cmd;
  logic        hdr_done, hdr_bad;
  logic        in_hs, room, wr_en;
  logic [LW-1:0] len_in;
  logic        size_bad, keep;
  logic [15:0] csum;
  logic [7:0]  rd_byte, byte_out;
  logic        patch_ok, patch_hi, patch_lo;
  logic        load, out_hs, fin;

  ckin_hdr_rx #(.WORDS(HDR_WORDS)) u_hdr (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .accept    (st_q == ST_HDR),
    .hdr_valid (hdr_valid),
    .hdr_data  (hdr_data),
    .hdr_last  (hdr_last),
    .hdr_ready (hdr_ready),
    .cmd       (cmd),
    .done      (hdr_done),
    .err       (hdr_bad)
  );

  assign in_ready = (st_q == ST_FRM);
  assign in_hs    = in_valid && in_ready;
  assign room     = cnt_q < LW'(BUF_BYTES);
  assign wr_en    = in_hs && room;
  assign len_in   = cnt_q + (wr_en ? LW'(1) : LW'(0));

  assign size_bad = !jumbo_en && !vlan_en &&
                    (32'(len_in) > 32'(STD_MAX)) && (32'(len_in) <= 32'(TAG_MAX));
  assign keep     = tx_en && !size_bad;

  ckin_sum #(.IW(AW)) u_sum (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .clr       (hdr_done),
    .en        (wr_en),
    .idx       (cnt_q[AW-1:0]),
    .start_off (cmd.start_off),
    .data      (in_data),
    .seed      (cmd.seed),
    .csum      (csum)
  );

  ckin_fbuf #(.DEPTH(BUF_BYTES), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (cnt_q[AW-1:0]),
    .wdata (in_data),
    .raddr (rd_q[AW-1:0]),
    .rdata (rd_byte)
  );

  // the checksum field must fit fully inside the stored frame
  assign patch_ok = cmd.csum_en && ((32'(cmd.wr_off) + 32'd1) < 32'(cnt_q));
  assign patch_hi = patch_ok && (32'(rd_q) == 32'(cmd.wr_off));
  assign patch_lo = patch_ok && (32'(rd_q) == (32'(cmd.wr_off) + 32'd1));
  assign byte_out = patch_hi ? csum[15:8] : (patch_lo ? csum[7:0] : rd_byte);

  assign load   = (st_q == ST_SEND) && (!ov_q || out_ready) && (rd_q < cnt_q);
  assign out_hs = ov_q && out_ready;
  assign fin    = out_hs && ol_q;

  always_comb begin
    st_nx    = st_q;
    cnt_nx   = cnt_q;
    rd_nx    = rd_q;
    ov_nx    = ov_q;
    od_nx    = od_q;
    ol_nx    = ol_q;
    done_nx  = 1'b0;
    bytes_nx = bytes_q;
    unique case (st_q)
      ST_HDR: begin
        if (hdr_done) begin
          st_nx  = ST_FRM;
          cnt_nx = '0;
        end
      end
      ST_FRM: begin
        cnt_nx = len_in;
        if (in_hs && in_last) begin
          rd_nx = '0;
          st_nx = keep ? ST_SEND : ST_HDR;
        end
      end
      ST_SEND: begin
        if (load) begin
          ov_nx = 1'b1;
          od_nx = byte_out;
          ol_nx = (rd_q + LW'(1)) == cnt_q;
          rd_nx = rd_q + LW'(1);
        end else if (out_hs) begin
          ov_nx = 1'b0;
        end
        if (fin) begin
          st_nx    = ST_HDR;
          done_nx  = 1'b1;
          bytes_nx = bytes_q + 64'(cnt_q);
        end
      end
      default: st_nx = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HDR;
      cnt_q   <= '0;
      rd_q    <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
      ol_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bytes_q <= '0;
    end else begin
      st_q    <= st_nx;
      cnt_q   <= cnt_nx;
      rd_q    <= rd_nx;
      ov_q    <= ov_nx;
      od_q    <= od_nx;
      ol_q    <= ol_nx;
      done_q  <= done_nx;
      err_q   <= hdr_bad;
      bytes_q <= bytes_nx;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;
  assign tx_done   = done_q;
  assign hdr_err   = err_q;
  assign tx_bytes  = bytes_q;

endmodule

// File: rtl/ckin_chk.sv
module ckin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_ready,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic        tx_done,
  input logic [63:0] tx_bytes
);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(out_valid && out_ready && out_last));

  // R8
  bytes_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bytes != $past(tx_bytes)) |-> tx_done);

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_ready && in_ready));

  // R9
  send_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

endmodule

bind tx_csum_insert ckin_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_ready (hdr_ready),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .tx_done   (tx_done),
  .tx_bytes  (tx_bytes)
);

// File: tb/sim_tx_csum_insert.sv
`timescale 1ns/1ps
module sim_tx_csum_insert;
  localparam int BUF = 2048;

  typedef struct packed {
    logic        ck;
    logic [15:0] st;
    logic [15:0] wo;
    logic [15:0] sd;
    logic [15:0] len;
    logic        en;
    logic        jb;
    logic        vl;
    logic [1:0]  rmode;
    logic [7:0]  salt;
  } vec_t;

  // ck st wo seed len en jb vl rmode salt
  localparam vec_t VECS [11] = '{
    '{1'b1, 16'd14,  16'd24,  16'h1234, 16'd64,   1'b1, 1'b0, 1'b0, 2'd0, 8'h11}, // R3 R4 even length
    '{1'b1, 16'd3,   16'd10,  16'hFFFF, 16'd63,   1'b1, 1'b0, 1'b0, 2'd1, 8'h5A}, // R3 odd tail, R9 stalls
    '{1'b0, 16'd0,   16'd2,   16'h0000, 16'd40,   1'b1, 1'b0, 1'b0, 2'd2, 8'h23}, // R2 untouched
    '{1'b1, 16'd0,   16'd62,  16'h0005, 16'd63,   1'b1, 1'b0, 1'b0, 2'd0, 8'h77}, // R5 offset = len-1
    '{1'b1, 16'd0,   16'd61,  16'h0007, 16'd63,   1'b1, 1'b0, 1'b0, 2'd2, 8'h31}, // R4 offset = len-2
    '{1'b1, 16'd20,  16'd4,   16'h0000, 16'd60,   1'b0, 1'b0, 1'b0, 2'd0, 8'h42}, // R6 disabled
    '{1'b0, 16'd0,   16'd0,   16'h0000, 16'd1519, 1'b1, 1'b0, 1'b0, 2'd0, 8'h09}, // R7 dropped
    '{1'b0, 16'd0,   16'd0,   16'h0000, 16'd1522, 1'b1, 1'b0, 1'b1, 2'd1, 8'h19}, // R7 tag allowed
    '{1'b1, 16'd100, 16'd200, 16'hBEEF, 16'd1523, 1'b1, 1'b0, 1'b0, 2'd0, 8'hC3}, // R7 above window
    '{1'b1, 16'd70,  16'd0,   16'h0F0F, 16'd64,   1'b1, 1'b0, 1'b0, 2'd0, 8'h66}, // R3 start past end
    '{1'b1, 16'd0,   16'd1516,16'h0000, 16'd1518, 1'b1, 1'b0, 1'b0, 2'd2, 8'hE1}  // R7 below window
  };

  logic clk, rst_n, tx_en, jumbo_en, vlan_en;
  logic hdr_valid, hdr_ready, hdr_last;
  logic [31:0] hdr_data;
  logic in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic out_valid, out_ready, out_last;
  logic [7:0] out_data;
  logic tx_done, hdr_err;
  logic [63:0] tx_bytes;

  tx_csum_insert #(.BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .jumbo_en(jumbo_en), .vlan_en(vlan_en),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data), .hdr_last(hdr_last),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .tx_done(tx_done), .hdr_err(hdr_err), .tx_bytes(tx_bytes)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests, fails;
  int got_n, last_cnt, last_at, done_cnt, err_cnt, hold_bad;
  logic [1:0] rmode;
  logic [7:0] got [BUF];
  logic [7:0] src [BUF];
  logic [7:0] expb [BUF];
  longint exp_total;
  logic pv, pr, pl;
  logic [7:0] pd;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // observer, away from the rising edge
  initial begin
    pv = 0; pr = 0; pl = 0; pd = 0;
    forever begin
      @(negedge clk);
      if (pv && !pr && (!out_valid || out_data != pd || out_last != pl)) hold_bad++;
      pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
      if (out_valid && out_ready) begin
        if (got_n < BUF) got[got_n] = out_data;
        if (out_last) begin last_cnt++; last_at = got_n; end
        got_n++;
      end
      if (tx_done) done_cnt++;
      if (hdr_err) err_cnt++;
    end
  end

  // output backpressure pattern
  initial begin
    int cyc;
    cyc = 0;
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (rmode)
        2'd1:    out_ready = cyc[0];
        2'd2:    out_ready = (cyc % 3) != 0;
        default: out_ready = 1'b1;
      endcase
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [7:0] gen(input int i, input logic [7:0] salt);
    return 8'((i * 29) + int'(salt) + (i >> 8));
  endfunction

  function automatic logic [15:0] ref_csum(input int len, input int st, input logic [15:0] seed);
    longint acc;
    acc = longint'(seed);
    for (int i = st; i < len; i += 2) begin
      acc += (longint'(src[i]) << 8) + ((i + 1 < len) ? longint'(src[i+1]) : 0);
    end
    while ((acc >> 16) != 0) acc = (acc & 64'hFFFF) + (acc >> 16);
    return ~acc[15:0];
  endfunction

  task automatic send_hdr(input int nw, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
    for (int k = 0; k < nw; k++) begin
      @(posedge clk); #1;
      hdr_valid = 1'b1;
      hdr_data  = (k == 0) ? w0 : (k == 1) ? w1 : (k == 2) ? w2 : (32'hA5A50000 + 32'(k));
      hdr_last  = (k == nw - 1);
      do @(negedge clk); while (!hdr_ready);
    end
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    hdr_last  = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic [7:0] salt);
    for (int i = 0; i < len; i++) begin
      if (i > 0) begin @(posedge clk); #1; end
      in_valid = 1'b1;
      in_data  = gen(i, salt);
      in_last  = (i == len - 1);
      do @(negedge clk); while (!in_ready);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  function automatic string vtag(input vec_t t, input int slen);
    if (!t.en) return "R6";
    if (slen > 1518 || (!t.jb && !t.vl && slen == 1518)) return "R7";
    if (slen > 2047) return "R10";
    if (t.ck && int'(t.wo) + 1 >= slen) return "R5";
    if (t.ck) return "R3/R4";
    return "R2";
  endfunction

  task automatic run_vec(input vec_t t);
    int slen, d0, k;
    bit kept;
    logic [15:0] c;
    string tg;
    slen = (int'(t.len) > BUF) ? BUF : int'(t.len);
    kept = t.en && !(!t.jb && !t.vl && slen > 1518 && slen <= 1522);
    for (int i = 0; i < slen; i++) begin src[i] = gen(i, t.salt); expb[i] = src[i]; end
    c = ref_csum(slen, int'(t.st), t.sd);
    if (t.ck && int'(t.wo) + 1 < slen) begin
      expb[t.wo] = c[15:8];
      expb[int'(t.wo) + 1] = c[7:0];
    end
    tg = vtag(t, slen);
    tx_en = t.en; jumbo_en = t.jb; vlan_en = t.vl; rmode = t.rmode;
    got_n = 0; last_cnt = 0; last_at = -1; hold_bad = 0;
    d0 = done_cnt;
    send_hdr(5, {31'd0, t.ck}, {t.st, t.wo}, {16'h0000, t.sd});
    send_frame(int'(t.len), t.salt);
    k = 0;
    if (kept) begin
      while (done_cnt == d0 && k < slen * 4 + 200) begin @(negedge clk); k++; end
      repeat (3) @(negedge clk);
      exp_total += slen;
    end else begin
      repeat (30) @(negedge clk);
    end
    chk(got_n == (kept ? slen : 0), {tg, " byte count"}, got_n, kept ? slen : 0);
    k = 0;
    for (int i = 0; i < slen && kept; i++) if (got[i] !== expb[i]) k++;
    chk(k == 0, {tg, " mismatched bytes"}, k, 0);
    chk(last_cnt == (kept ? 1 : 0) && (!kept || last_at == slen - 1), "R9 last marker", last_at, kept ? slen - 1 : -1);
    chk(done_cnt - d0 == (kept ? 1 : 0), "R8 tx_done count", done_cnt - d0, kept ? 1 : 0);
    chk(tx_bytes == 64'(exp_total), "R8 tx_bytes", longint'(tx_bytes), exp_total);
    chk(hold_bad == 0, "R9 hold under stall", hold_bad, 0);
    rmode = 2'd0;
  endtask

  initial begin
    int e0;
    vec_t tv;
    tests = 0; fails = 0; got_n = 0; last_cnt = 0; last_at = -1;
    done_cnt = 0; err_cnt = 0; hold_bad = 0; exp_total = 0; rmode = 2'd0;
    rst_n = 1'b0; tx_en = 1'b1; jumbo_en = 1'b0; vlan_en = 1'b0;
    hdr_valid = 1'b0; hdr_data = '0; hdr_last = 1'b0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    chk(tx_done == 1'b0 && hdr_err == 1'b0, "R11 pulses", tx_done, 0);
    chk(tx_bytes == 64'd0, "R11 tx_bytes", longint'(tx_bytes), 0);
    chk(hdr_ready == 1'b1, "R11 hdr_ready", hdr_ready, 1);
    chk(in_ready == 1'b0, "R11 in_ready", in_ready, 0);

    // R1 short header
    e0 = err_cnt;
    send_hdr(3, 32'd1, 32'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(err_cnt - e0 == 1, "R1 short header error", err_cnt - e0, 1);
    chk(in_ready == 1'b0 && hdr_ready == 1'b1, "R1 frame still blocked", in_ready, 0);
    // R1 long header
    send_hdr(6, 32'd1, 32'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk(err_cnt - e0 == 2, "R1 long header error", err_cnt - e0, 2);
    chk(in_ready == 1'b0 && hdr_ready == 1'b1, "R1 frame still blocked after long", in_ready, 0);

    for (int v = 0; v < 11; v++) run_vec(VECS[v]);

    // R10 truncation beyond the buffer
    tv = '{1'b1, 16'd0, 16'd100, 16'h2222, 16'd2100, 1'b1, 1'b1, 1'b0, 2'd0, 8'h3C};
    run_vec(tv);
    chk(err_cnt - e0 == 2, "R1 no spurious header error", err_cnt - e0, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule